// File: doc/BRIEF.md
# Colour Lookup Table with Sequenced Byte Access

This block holds a 256-entry colour table, each entry a red, green and blue byte. A host reaches it through a narrow byte interface. There are three registers: an index for loading, an index for fetching, and one data port. A full colour takes three accesses to the data port, always red first, then green, then blue. A small state machine tracks which component comes next. Both index registers use that one sequencer. After the blue access it moves the index that was used on to the next entry, so a whole table can be loaded or dumped in one burst after a single index setup.

A second, independent port serves display logic. It takes a pixel index and returns the packed 24-bit colour one cycle later. Host traffic never stalls it.

The sequencer has three named states: `C_RED`, `C_GRN` and `C_BLU`. Its transitions are:
- ADVANCE: any data-port access moves `C_RED`→`C_GRN`→`C_BLU`.
- WRAP: a data-port access in `C_BLU` moves to `C_RED` and steps the index that was used.
- RESTART: a write to either index register forces `C_RED`. RESTART takes priority over the others.

Top module: `clut_port`

## Requirements
- R1: After reset both indices read 0, the sequencer is in `C_RED` and `hst_rdata` is 0.
- R2: A write with `hst_sel`=0 loads the load index, and a write with `hst_sel`=2 loads the fetch index. A read of either code returns that index on `hst_rdata` in the cycle after the strobe.
- R3: A write with `hst_sel`=1 stores `hst_wdata` into the current component of the entry at the load index. The components go in the order red, green, blue. The load index steps by one after the blue write, and the fetch index is left unchanged.
- R4: A read with `hst_sel`=1 returns the current component of the entry at the fetch index, in the cycle after the strobe. The fetch index steps by one after the blue read.
- R5: Writing either index register returns the sequencer to red, even in the middle of a triple.
- R6: Reads and writes share one sequencer: a data read that follows a partial write triple returns the next component in order.
- R7: Both indices wrap from 255 to 0.
- R8: `px_color` holds the entry selected by `px_idx` one cycle earlier, packed as red in bits 23:16, green in 15:8 and blue in 7:0.
- R9: `hst_sel`=3 is reserved. Writes to it change nothing, and reads of it return 0.
- R10: If `hst_wr` and `hst_rd` are high together, only the write happens, and `hst_rdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_sel | input | 2 | Register select: 0 load index, 1 data, 2 fetch index, 3 reserved |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Registered host read byte |
| px_idx | input | 8 | Display lookup index |
| px_color | output | 24 | Display colour, one cycle after `px_idx` |

## Verification
The bench builds the block with its default parameters: an 8-bit index, 8-bit components and three components per entry. This configuration is small enough to sweep completely. Every entry is loaded through one burst and dumped through another, which drives both indices through their 255-to-0 wrap. Every entry is also fetched through the display port. Directed sequences then interleave index writes, half-finished triples, reserved-select accesses and simultaneous strobes, so that the sequencer's RESTART transition and its sharing between reads and writes are both exercised.

// File: rtl/clut_pkg.sv
package clut_pkg;
    typedef enum logic [1:0] {
        C_RED = 2'd0,
        C_GRN = 2'd1,
        C_BLU = 2'd2
    } comp_e;

    localparam logic [1:0] SEL_WIDX = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_RIDX = 2'd2;
    localparam logic [1:0] SEL_RSVD = 2'd3;
endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       restart,
    output logic [1:0] comp,
    output logic       last
);
    comp_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= C_RED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = C_RED;
        end else if (step) begin
            unique case (state_q)
                C_RED:   state_d = C_GRN;
                C_GRN:   state_d = C_BLU;
                C_BLU:   state_d = C_RED;
                default: state_d = C_RED;
            endcase
        end
    end

    always_comb begin
        comp = state_q;
        last = (state_q == C_BLU);
    end
endmodule

// File: rtl/clut_idx.sv
module clut_idx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         bump,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= load_val;
        else if (bump) q <= q + 1'b1;
    end
endmodule

// File: rtl/clut_store.sv
module clut_store #(
    parameter int IDX_W = 8,
    parameter int CW    = 8,
    parameter int NCOMP = 3
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [1:0]          wr_comp,
    input  logic [CW-1:0]       wr_data,
    input  logic [IDX_W-1:0]    hrd_idx,
    input  logic [1:0]          hrd_comp,
    output logic [CW-1:0]       hrd_data,
    input  logic [IDX_W-1:0]    px_idx,
    output logic [NCOMP*CW-1:0] px_color
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int NLANE = 4;

    logic [CW-1:0] lane [NLANE];

    for (genvar c = 0; c < NLANE; c++) begin : g_lane
        if (c < NCOMP) begin : g_mem
            logic [CW-1:0] mem [DEPTH];

            always_ff @(posedge clk) begin
                if (wr_en && wr_comp == 2'(c)) mem[wr_idx] <= wr_data;
            end

            always_ff @(posedge clk) begin
                px_color[(NCOMP-1-c)*CW +: CW] <= mem[px_idx];
            end

            assign lane[c] = mem[hrd_idx];
        end else begin : g_pad
            assign lane[c] = '0;
        end
    end

    assign hrd_data = lane[hrd_comp];
endmodule

// File: rtl/clut_port.sv
module clut_port
    import clut_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int CW    = 8,
    parameter int NCOMP = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hst_wr,
    input  logic                hst_rd,
    input  logic [1:0]          hst_sel,
    input  logic [CW-1:0]       hst_wdata,
    output logic [CW-1:0]       hst_rdata,
    input  logic [IDX_W-1:0]    px_idx,
    output logic [NCOMP*CW-1:0] px_color
);
    logic             rd_go, data_wr, data_rd, widx_wr, ridx_wr;
    logic [1:0]       comp_q;
    logic             comp_last;
    logic [IDX_W-1:0] wr_idx_q, rd_idx_q;
    logic [CW-1:0]    lut_byte;

    always_comb begin
        rd_go   = hst_rd && !hst_wr;
        data_wr = hst_wr && (hst_sel == SEL_DATA);
        widx_wr = hst_wr && (hst_sel == SEL_WIDX);
        ridx_wr = hst_wr && (hst_sel == SEL_RIDX);
        data_rd = rd_go  && (hst_sel == SEL_DATA);
    end

    clut_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (data_wr || data_rd),
        .restart (widx_wr || ridx_wr),
        .comp    (comp_q),
        .last    (comp_last)
    );

    clut_idx #(.W(IDX_W)) u_widx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (widx_wr),
        .load_val (hst_wdata[IDX_W-1:0]),
        .bump     (data_wr && comp_last),
        .q        (wr_idx_q)
    );

    clut_idx #(.W(IDX_W)) u_ridx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ridx_wr),
        .load_val (hst_wdata[IDX_W-1:0]),
        .bump     (data_rd && comp_last),
        .q        (rd_idx_q)
    );

    clut_store #(.IDX_W(IDX_W), .CW(CW), .NCOMP(NCOMP)) u_store (
        .clk      (clk),
        .wr_en    (data_wr),
        .wr_idx   (wr_idx_q),
        .wr_comp  (comp_q),
        .wr_data  (hst_wdata),
        .hrd_idx  (rd_idx_q),
        .hrd_comp (comp_q),
        .hrd_data (lut_byte),
        .px_idx   (px_idx),
        .px_color (px_color)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hst_rdata <= '0;
        end else if (rd_go) begin
            unique case (hst_sel)
                SEL_WIDX: hst_rdata <= CW'(wr_idx_q);
                SEL_DATA: hst_rdata <= lut_byte;
                SEL_RIDX: hst_rdata <= CW'(rd_idx_q);
                default:  hst_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/clut_port_chk.sv
module clut_port_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hst_wr,
    input logic             hst_rd,
    input logic [1:0]       hst_sel,
    input logic [1:0]       comp_q,
    input logic [IDX_W-1:0] wr_idx_q,
    input logic [IDX_W-1:0] rd_idx_q
);
    logic dwr, drd;
    assign dwr = hst_wr && hst_sel == 2'd1;
    assign drd = hst_rd && !hst_wr && hst_sel == 2'd1;

    a_r3_blue_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((dwr || drd) && comp_q == 2'd2) |=> comp_q == 2'd0);

    a_r5_index_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr && (hst_sel == 2'd0 || hst_sel == 2'd2)) |=> comp_q == 2'd0);

    a_r3_widx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr && comp_q == 2'd2) |=> wr_idx_q == $past(wr_idx_q) + 1'b1);

    a_r3_widx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr && comp_q != 2'd2) |=> $stable(wr_idx_q));

    a_r3_ridx_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        dwr |=> $stable(rd_idx_q));

    a_r4_ridx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (drd && comp_q == 2'd2) |=> rd_idx_q == $past(rd_idx_q) + 1'b1);

    a_r9_reserved_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr && hst_sel == 2'd3) |=>
            ($stable(wr_idx_q) && $stable(rd_idx_q) && $stable(comp_q)));

    a_r1_comp_legal: assert property (@(posedge clk) disable iff (!rst_n)
        comp_q != 2'd3);
endmodule

bind clut_port clut_port_chk #(.IDX_W(IDX_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hst_wr   (hst_wr),
    .hst_rd   (hst_rd),
    .hst_sel  (hst_sel),
    .comp_q   (comp_q),
    .wr_idx_q (wr_idx_q),
    .rd_idx_q (rd_idx_q)
);

// File: tb/clut_port_tb_top.sv
`timescale 1ns/1ps
module clut_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_wr = 1'b0, hst_rd = 1'b0;
    logic [1:0]  hst_sel = 2'd0;
    logic [7:0]  hst_wdata = 8'd0;
    logic [7:0]  hst_rdata;
    logic [7:0]  px_idx = 8'd0;
    logic [23:0] px_color;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    clut_port dut_i (
        .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
        .hst_sel(hst_sel), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .px_idx(px_idx), .px_color(px_color)
    );

    function automatic logic [7:0] pat(input int e, input int c);
        return 8'((e * 37 + c * 101 + 11) & 255);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        hst_sel = s; hst_wdata = d; hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic hrd(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        hst_sel = s; hst_rd = 1'b1;
        @(negedge clk);
        hst_rd = 1'b0;
        v = hst_rdata;
    endtask

    task automatic look(input int e, output logic [23:0] v);
        @(negedge clk);
        px_idx = 8'(e);
        @(negedge clk);
        v = px_color;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v;
        logic [23:0] col;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 rdata", 32'(hst_rdata), 32'h0);
        hrd(2'd0, v); check("R1 load index", 32'(v), 32'h0);
        hrd(2'd2, v); check("R1 fetch index", 32'(v), 32'h0);

        // R3 full burst load, R7 wrap of load index
        hwr(2'd0, 8'd0);
        for (int e = 0; e < 256; e++)
            for (int c = 0; c < 3; c++) hwr(2'd1, pat(e, c));
        hrd(2'd0, v); check("R7 load index wrap", 32'(v), 32'h0);
        hrd(2'd2, v); check("R3 fetch index untouched", 32'(v), 32'h0);

        // R4 full burst dump, R7 wrap of fetch index
        hwr(2'd2, 8'd0);
        for (int e = 0; e < 256; e++)
            for (int c = 0; c < 3; c++) begin
                hrd(2'd1, v);
                check($sformatf("R4 entry %0d comp %0d", e, c), 32'(v), 32'(pat(e, c)));
            end
        hrd(2'd2, v); check("R7 fetch index wrap", 32'(v), 32'h0);

        // R8 display sweep
        for (int e = 0; e < 256; e++) begin
            look(e, col);
            check($sformatf("R8 entry %0d", e), 32'(col),
                  32'({pat(e, 0), pat(e, 1), pat(e, 2)}));
        end

        // R2 index load and readback
        hwr(2'd0, 8'd5);
        hrd(2'd0, v); check("R2 load index", 32'(v), 32'd5);
        hwr(2'd1, 8'hAA);
        hwr(2'd1, 8'hBB);
        // R5 fetch-index write restarts the sequencer mid-triple
        hwr(2'd2, 8'd9);
        hrd(2'd2, v); check("R2 fetch index", 32'(v), 32'd9);
        hrd(2'd1, v); check("R5 restart to red", 32'(v), 32'(pat(9, 0)));
        look(5, col); check("R5 partial triple", 32'(col), 32'({8'hAA, 8'hBB, pat(5, 2)}));

        // R6 shared sequencer
        hwr(2'd0, 8'd20);
        hwr(2'd1, 8'h11);
        hrd(2'd1, v); check("R6 read follows write order", 32'(v), 32'(pat(9, 1)));
        hwr(2'd1, 8'h22);
        look(20, col); check("R6 interleaved entry", 32'(col), 32'({8'h11, pat(20, 1), 8'h22}));
        hrd(2'd0, v); check("R6 load index stepped", 32'(v), 32'd21);
        hrd(2'd2, v); check("R6 fetch index held", 32'(v), 32'd9);

        // R9 reserved select
        hwr(2'd3, 8'h77);
        hrd(2'd0, v); check("R9 load index kept", 32'(v), 32'd21);
        hrd(2'd2, v); check("R9 fetch index kept", 32'(v), 32'd9);
        hrd(2'd1, v); check("R9 sequencer kept", 32'(v), 32'(pat(9, 0)));
        hrd(2'd3, v); check("R9 reserved reads 0", 32'(v), 32'h0);
        look(21, col); check("R9 table kept", 32'(col), 32'({pat(21, 0), pat(21, 1), pat(21, 2)}));

        // R10 simultaneous strobes: write wins, rdata holds
        hrd(2'd1, v); check("R10 setup", 32'(v), 32'(pat(9, 1)));
        hwr(2'd0, 8'd21);
        @(negedge clk);
        hst_sel = 2'd1; hst_wdata = 8'h5C; hst_wr = 1'b1; hst_rd = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0; hst_rd = 1'b0;
        check("R10 rdata held", 32'(hst_rdata), 32'(pat(9, 1)));
        look(21, col); check("R10 write done", 32'(col), 32'({8'h5C, pat(21, 1), pat(21, 2)}));
        hwr(2'd1, 8'h6D);
        look(21, col); check("R10 single advance", 32'(col), 32'({8'h5C, 8'h6D, pat(21, 2)}));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule